// File: doc/BRIEF.md
# DRAM Burst Transfer Splitter

This block takes a byte-granular transfer request (start byte address, byte count, direction) and breaks it into a sequence of fixed-length burst commands for a double-data-rate memory. Each command carries only the row and starting column of its burst. The memory then steps the column by one word per beat on its own. The block sequences the bursts, steps the word address from burst to burst, and marks every beat and byte lane as carrying requested data or not.

Requests whose ends do not line up with a word or a burst need no separate single-beat path. The burst is always issued at full length. On writes, the byte lanes outside the request are masked. On reads, the beats outside the request are flagged as not valid. A burst that would run past the last column of a row is cut at the row end, and the next burst starts at column 0 of the following row. Two beats move per clock, so a burst of N beats lasts N/2 cycles.

Byte addresses are laid out as {row, column, byte-in-word}. The default is a 16-bit device, so each word is 2 bytes and the byte-in-word field is 1 bit. Each row has 16 columns and there are 8 row bits.

Top module: `burst_splitter`

## Requirements
- R1: `bl_sel` is sampled when a request is accepted and sets the burst length: 0 gives 2 beats, 1 gives 4 beats, 2 or 3 gives 8 beats. Each burst keeps `data_active` high for burst-length/2 consecutive cycles.
- R2: Exactly one `cmd_valid` cycle is issued per burst, on the first cycle of that burst. The first burst's command appears in the second cycle after the accepting clock edge. `cmd_row`/`cmd_col` give the burst's start word, and `cmd_write` equals the request's write flag.
- R3: Within a row, each burst after the first starts exactly burst-length words after the previous one.
- R4: When a burst would pass the last column of a row, its beats beyond the row end are flagged not valid, and the next burst starts at column 0 of the next row.
- R5: `beat_mask` has one bit per byte lane, and 1 means masked. Lane k of beat slot j is bit j*NB+k, where beat slot 0 is the earlier beat of the cycle. Over a request, exactly the requested bytes are unmasked, so the count of unmasked lanes equals `req_len`.
- R6: `beat_ok[j]` is 1 only for a beat whose word lies inside the request and inside the current row. A beat with `beat_ok` low has all its lanes masked.
- R7: `req_ready` is high while idle, goes low in the cycle after an accepting edge, and no request is taken until the last burst of the current one has been issued.
- R8: `done` is high for exactly one cycle, in the cycle right after the final beat cycle of a request.
- R9: Reset, synchronous and active high, returns the block to idle from any point: `req_ready` high, with `cmd_valid`, `data_active`, `beat_ok` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ROW_W+COL_W+log2(DEV_W/8) | Start byte address {row, col, byte} |
| req_len | input | LEN_W | Byte count, must be at least 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| bl_sel | input | 2 | Burst length select |
| cmd_valid | output | 1 | Burst command strobe |
| cmd_write | output | 1 | Direction of the command |
| cmd_row | output | ROW_W | Row of the burst |
| cmd_col | output | COL_W | Start column of the burst |
| data_active | output | 1 | A beat pair of a burst occupies this cycle |
| beat_ok | output | 2 | Per beat slot: beat carries requested data |
| beat_mask | output | 2*DEV_W/8 | Per byte lane mask, 1 = masked |
| done | output | 1 | Request finished pulse |

## Verification
All outputs are registered. The first command follows the accepting edge by two edges, `req_ready` falls one edge after acceptance, and `done` comes one cycle after the last `data_active` cycle. The bench drives on falling edges and samples on falling edges. It numbers the cycles from the acceptance, so each latency is compared against its exact cycle index and not against a window. Per request, it accumulates command count, valid beats, unmasked lanes, active cycles and the first two command addresses, and compares these totals with values worked out by hand from the requirements.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  // burst length in beats from the select code
  function automatic logic [3:0] beats_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/bsplit_beat.sv
module bsplit_beat #(
  parameter int WA_W   = 12,
  parameter int OFS_W  = 1,
  parameter int ADDR_W = WA_W + OFS_W
) (
  input  logic [WA_W-1:0]     word_addr,
  input  logic                in_row,
  input  logic [ADDR_W-1:0]   first_byte,
  input  logic [ADDR_W-1:0]   last_byte,
  output logic                ok,
  output logic [(1<<OFS_W)-1:0] mask
);
  localparam int NB = 1 << OFS_W;

  always_comb begin
    ok = in_row
      && (word_addr >= first_byte[ADDR_W-1:OFS_W])
      && (word_addr <= last_byte[ADDR_W-1:OFS_W]);
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [ADDR_W-1:0] baddr;
    assign baddr   = {word_addr, OFS_W'(k)};
    assign mask[k] = !(ok && (baddr >= first_byte) && (baddr <= last_byte));
  end
endmodule

// File: rtl/bsplit_step.sv
module bsplit_step #(
  parameter int ROW_W = 8,
  parameter int COL_W = 4
) (
  input  logic [ROW_W+COL_W-1:0] cur_wa,
  input  logic [3:0]             bl,
  output logic [ROW_W+COL_W-1:0] next_wa
);
  localparam int WA_W = ROW_W + COL_W;
  localparam int COLS = 1 << COL_W;

  logic [COL_W:0] col_end;
  logic           crosses;

  always_comb begin
    col_end = {1'b0, cur_wa[COL_W-1:0]} + (COL_W+1)'(bl);
    crosses = col_end > (COL_W+1)'(COLS);
    if (crosses)
      next_wa = {cur_wa[WA_W-1:COL_W] + ROW_W'(1), COL_W'(0)};
    else
      next_wa = cur_wa + WA_W'(bl);
  end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int DEV_W = 16,
  parameter int COL_W = 4,
  parameter int ROW_W = 8,
  parameter int LEN_W = 10,
  localparam int NB     = DEV_W / 8,
  localparam int OFS_W  = $clog2(NB),
  localparam int WA_W   = ROW_W + COL_W,
  localparam int ADDR_W = WA_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [1:0]        bl_sel,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              data_active,
  output logic [1:0]        beat_ok,
  output logic [2*NB-1:0]   beat_mask,
  output logic              done
);
  import bsplit_pkg::*;

  // sequencer state
  logic              busy;
  logic [WA_W-1:0]   wa;
  logic [1:0]        pidx;
  logic [3:0]        bl;
  logic              wr;
  logic [ADDR_W-1:0] first_byte, last_byte;
  logic              fin;

  logic [WA_W-1:0]   next_wa;
  logic              last_pair, last_burst;
  logic [1:0]        slot_ok;
  logic [2*NB-1:0]   slot_mask;

  bsplit_step #(.ROW_W(ROW_W), .COL_W(COL_W)) u_step (
    .cur_wa(wa), .bl(bl), .next_wa(next_wa)
  );

  for (genvar j = 0; j < 2; j++) begin : g_slot
    logic [2:0]       bidx;
    logic [COL_W:0]   colsum;
    logic [WA_W-1:0]  bword;
    assign bidx   = {pidx, 1'(j)};
    assign colsum = {1'b0, wa[COL_W-1:0]} + (COL_W+1)'(bidx);
    assign bword  = wa + WA_W'(bidx);
    bsplit_beat #(.WA_W(WA_W), .OFS_W(OFS_W)) u_beat (
      .word_addr (bword),
      .in_row    (!colsum[COL_W]),
      .first_byte(first_byte),
      .last_byte (last_byte),
      .ok        (slot_ok[j]),
      .mask      (slot_mask[j*NB +: NB])
    );
  end

  assign last_pair  = ({1'b0, pidx} + 3'd1) == bl[3:1];
  assign last_burst = next_wa > last_byte[ADDR_W-1:OFS_W];
  assign req_ready  = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      wa          <= '0;
      pidx        <= '0;
      bl          <= 4'd2;
      wr          <= 1'b0;
      first_byte  <= '0;
      last_byte   <= '0;
      fin         <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      data_active <= 1'b0;
      beat_ok     <= '0;
      beat_mask   <= '1;
      done        <= 1'b0;
    end else begin
      fin         <= 1'b0;
      done        <= fin;
      cmd_valid   <= 1'b0;
      data_active <= 1'b0;
      beat_ok     <= '0;
      beat_mask   <= '1;
      if (!busy) begin
        if (req_valid) begin
          busy       <= 1'b1;
          wa         <= req_addr[ADDR_W-1:OFS_W];
          pidx       <= '0;
          bl         <= beats_of(bl_sel);
          wr         <= req_write;
          first_byte <= req_addr;
          last_byte  <= req_addr + ADDR_W'(req_len) - ADDR_W'(1);
        end
      end else begin
        data_active <= 1'b1;
        beat_ok     <= slot_ok;
        beat_mask   <= slot_mask;
        if (pidx == 2'd0) begin
          cmd_valid <= 1'b1;
          cmd_write <= wr;
          cmd_row   <= wa[WA_W-1:COL_W];
          cmd_col   <= wa[COL_W-1:0];
        end
        if (last_pair) begin
          pidx <= '0;
          wa   <= next_wa;
          if (last_burst) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end
        end else begin
          pidx <= pidx + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/bsplit_chk.sv
module bsplit_chk #(
  parameter int NB = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           cmd_valid,
  input logic           data_active,
  input logic [1:0]     beat_ok,
  input logic [2*NB-1:0] beat_mask,
  input logic           done
);
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_cmd_inside_burst: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> data_active);

  a_r8_done_after_last_beat: assert property (@(posedge clk) disable iff (rst)
    done |-> (!data_active && $past(data_active)));

  a_r6_slot0_masked: assert property (@(posedge clk) disable iff (rst)
    !beat_ok[0] |-> (&beat_mask[NB-1:0]));

  a_r6_slot1_masked: assert property (@(posedge clk) disable iff (rst)
    !beat_ok[1] |-> (&beat_mask[2*NB-1:NB]));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind burst_splitter bsplit_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .data_active(data_active), .beat_ok(beat_ok),
  .beat_mask(beat_mask), .done(done)
);

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
  localparam int NB = 2, ROW_W = 8, COL_W = 4, LEN_W = 10;
  localparam int ADDR_W = ROW_W + COL_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [1:0] bl_sel = 2'd0;
  logic cmd_valid, cmd_write, data_active, done;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [1:0] beat_ok;
  logic [2*NB-1:0] beat_mask;

  always #10 clk = ~clk;

  burst_splitter dut (.*);

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sel;
    logic [12:0] addr;
    logic [9:0]  len;
    logic [7:0]  cmds;
    logic [7:0]  oks;
    logic [7:0]  cyc;
    logic [7:0]  row1;
    logic [3:0]  col1;
    logic [7:0]  row2;
    logic [3:0]  col2;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 13'h000, 10'd16, 8'd4, 8'd8,  8'd4,  8'd0, 4'd0,  8'd0, 4'd2},
    '{1'b1, 2'd1, 13'h003, 10'd5,  8'd1, 8'd3,  8'd2,  8'd0, 4'd1,  8'd0, 4'd0},
    '{1'b0, 2'd2, 13'h018, 10'd10, 8'd2, 8'd5,  8'd8,  8'd0, 4'd12, 8'd1, 4'd0},
    '{1'b1, 2'd2, 13'h101, 10'd1,  8'd1, 8'd1,  8'd4,  8'd8, 4'd0,  8'd0, 4'd0},
    '{1'b1, 2'd0, 13'h01F, 10'd2,  8'd2, 8'd2,  8'd2,  8'd0, 4'd15, 8'd1, 4'd0},
    '{1'b0, 2'd1, 13'h000, 10'd64, 8'd8, 8'd32, 8'd16, 8'd0, 4'd0,  8'd0, 4'd4},
    '{1'b1, 2'd3, 13'h000, 10'd16, 8'd1, 8'd8,  8'd4,  8'd0, 4'd0,  8'd0, 4'd0}
  };

  task automatic run_vec(input vec_t v);
    int n = 0, cmds = 0, oks = 0, cyc = 0, unm = 0, badwr = 0, first_n = -1;
    int r1 = -1, c1 = -1, r2 = -1, c2 = -1;
    logic prev_act = 1'b0;
    logic seen_done = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; bl_sel = v.sel;
    req_addr = v.addr; req_len = v.len;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low after accept", int'(req_ready), 0);
    while (!seen_done && n < 200) begin
      @(negedge clk);
      n++;
      if (cmd_valid) begin
        cmds++;
        if (first_n < 0) first_n = n;
        if (cmd_write != v.wr) badwr++;
        if (cmds == 1) begin r1 = cmd_row; c1 = cmd_col; end
        if (cmds == 2) begin r2 = cmd_row; c2 = cmd_col; end
      end
      if (data_active) begin
        cyc++;
        oks += $countones(beat_ok);
        for (int b = 0; b < 2*NB; b++) if (!beat_mask[b]) unm++;
      end
      if (done) begin
        seen_done = 1'b1;
        chk("R8 done right after last beat cycle", int'(prev_act && !data_active), 1);
      end
      prev_act = data_active;
    end
    chk("R8 done seen (watchdog)", int'(seen_done), 1);
    chk("R2 first command latency", first_n, 1);
    chk("R2 command count", cmds, int'(v.cmds));
    chk("R2 cmd_write matches", badwr, 0);
    chk("R6 valid beat count", oks, int'(v.oks));
    chk("R1 active cycles", cyc, int'(v.cyc));
    chk("R5 unmasked lanes equal length", unm, int'(v.len));
    chk("R2 first row", r1, int'(v.row1));
    chk("R2 first col", c1, int'(v.col1));
    if (v.cmds >= 2) begin
      chk("R3/R4 second row", r2, int'(v.row2));
      chk("R3/R4 second col", c2, int'(v.col2));
    end
    @(negedge clk);
    chk("R8 done one cycle only", int'(done), 0);
    chk("R7 ready high when idle", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ready in reset", int'(req_ready), 1);
    chk("R9 cmd_valid in reset", int'(cmd_valid), 0);
    chk("R9 data_active in reset", int'(data_active), 0);
    chk("R9 done in reset", int'(done), 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9 reset in mid-request
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; bl_sel = 2'd1;
    req_addr = '0; req_len = 10'd64;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 busy before reset", int'(data_active), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 ready after reset", int'(req_ready), 1);
    chk("R9 data_active after reset", int'(data_active), 0);
    chk("R9 beat_ok after reset", int'(beat_ok), 0);
    repeat (3) @(negedge clk);
    chk("R9 stays idle", int'(data_active), 0);

    // R1 odd tail read at burst length 4 after a reset
    run_vec('{1'b0, 2'd1, 13'h001, 10'd2, 8'd1, 8'd2, 8'd2, 8'd0, 4'd0, 8'd0, 4'd0});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule